// File: doc/BRIEF.md
# DRAM Timing Margin Test Sequencer

This block runs one margin test on one DRAM row at a time. It first stores a known data pattern in the row with full timing. It then replays a short command sequence in which exactly one spacing is shortened to a programmable number of controller cycles:

- **Activation test:** the shortened spacing is row-open to first column read.
- **Precharge test:** the shortened spacing is bank-close to opening a different row.

The row is then read again with full spacing. Bits that differ from the pattern are counted separately for the two passes. A fault that shows up only in the shortened pass is a timing fault. A fault that shows up in both passes is a stored-data fault.

The sequencer drives an abstract command bus: a command code with bank, row, column and write data. One command is issued per cycle at most. Read data comes back on a valid/ready stream:
- The sequencer raises `rd_ready` only while it waits for the data of the read it has just issued.
- A beat transfers on a rising edge where `rd_valid` and `rd_ready` are both high.
- The memory side may hold `rd_valid` low for as long as it likes, and the sequencer waits.
- The sequencer never withdraws `rd_ready` before the transfer.

Host control is plain: configuration pins, a start pulse, a busy level, a done pulse and two error counts.

Top module: `dram_margin_seq`

## Requirements
- R1: After reset, `busy`, `done` and `rd_ready` are 0, `cmd` is NOP (code 0), and both error counts are 0.
- R2: A `start` sampled high while idle makes `busy` 1 from the next cycle. At the end of the test, `done` is high for exactly one cycle, with `busy` already 0 in that cycle.
- R3: A `start` sampled while a test is running is ignored. The configuration latched at acceptance stays in use.
- R4: Every test begins with a preparation phase:
  - ACT (code 1) of the target row.
  - NOM_DLY cycles later, N_LINES writes (code 3) on consecutive cycles to columns col, col+1, … (wrapping modulo the column space).
  - NOM_DLY cycles after the last write, PRE (code 4).
  - NOM_DLY cycles after that PRE, the first command of the test.
- R5: In the activation test (`test_mode`=0):
  - ACT of the target row, then the first read (code 2) of column col exactly D cycles later.
  - NOM_DLY cycles after that read's data transfers, a second read of the same column.
  - After its data, a PRE.
  - Two reads in total.
- R6: In the precharge test (`test_mode`=1):
  - ACT of the alternate row, then PRE NOM_DLY cycles later.
  - ACT of the target row exactly D cycles after that PRE.
  - N_LINES reads of columns col, col+1, …
  - Then PRE, ACT of the target row and the same N_LINES reads again, all spaced NOM_DLY.
  - 2·N_LINES reads in total.
- R7: The pattern code selects the data for each column:
  - 0: all zeros.
  - 1: all ones.
  - 2: alternating bits with bit 0 set.
  - 3: the code-2 word on even columns and its inverse on odd columns.
- R8: `err_fast` adds the number of bits that differ from the column's pattern over the reduced-timing reads (the first read in test 0, the first N_LINES reads in test 1). `err_ref` does the same over the full-timing reads.
- R9: Both counts saturate at 2^CNT_W−1 and never wrap.
- R10: `rd_ready` is high only while a read's data is awaited. No command is issued in those cycles.
- R11: Both counts are cleared in the cycle a start is accepted. They hold their values after `done` until the next accepted start.
- R12: D is `cfg_delay` latched at start, with 0 treated as 1. Values at or above NOM_DLY are used as given.
- R13: Every command carries the bank latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a test when idle |
| test_mode | input | 1 | 0 activation test, 1 precharge test |
| cfg_bank | input | BANK_W | Bank under test |
| cfg_row | input | ROW_W | Row under test |
| cfg_alt_row | input | ROW_W | Other row of the same bank (precharge test) |
| cfg_col | input | COL_W | First column |
| cfg_pattern | input | 2 | Pattern code |
| cfg_delay | input | DLY_W | Reduced spacing in cycles |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| cmd | output | 3 | Command code: 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRE |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for ACT |
| cmd_col | output | COL_W | Column for READ/WRITE |
| wr_data | output | DW | Write data with WRITE |
| rd_valid | input | 1 | Read data valid |
| rd_ready | output | 1 | Sequencer accepts read data |
| rd_data | input | DW | Read data |
| err_fast | output | CNT_W | Bit errors in reduced-timing reads |
| err_ref | output | CNT_W | Bit errors in full-timing reads |

## Verification
- **After start:** `busy` and the cleared counts are due one cycle after the accepting edge, so they are sampled at the following falling edge.
- **Command spacing:** a model of the memory timestamps every command at falling edges. The spacings from R4–R6 are differences of those timestamps. The model injects bit flips only when a spacing falls below its own fault threshold, so the expected counts follow from the measured spacings and the pattern.
- **Read data:** data is returned after a random latency of two to four cycles, to exercise the stall.
- **End of test:** the counts are read in the cycle `done` is seen, and again one cycle later to confirm they hold.

// File: rtl/dram_margin_pkg.sv
package dram_margin_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_WAIT,
    S_P_ACT,
    S_P_WR,
    S_P_PRE,
    S_A_ACT,
    S_A_RD,
    S_A_RW,
    S_A_RD2,
    S_A_RW2,
    S_C_ACTO,
    S_C_PRE,
    S_C_ACT,
    S_C_RD,
    S_C_RW,
    S_C_PRE2,
    S_C_ACT2,
    S_C_RD2,
    S_C_RW2,
    S_F_PRE,
    S_DONE
  } seq_state_e;

endpackage

// File: rtl/dmt_pattern.sv
module dmt_pattern #(
  parameter int DW = 16
) (
  input  logic [1:0]    sel,
  input  logic          odd_col,
  output logic [DW-1:0] word
);
  localparam logic [DW-1:0] ALT = {(DW/2){2'b01}};

  always_comb begin
    case (sel)
      2'd0:    word = '0;
      2'd1:    word = '1;
      2'd2:    word = ALT;
      default: word = odd_col ? ~ALT : ALT;
    endcase
  end
endmodule

// File: rtl/dmt_gap_timer.sv
module dmt_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dmt_err_acc.sv
module dmt_err_acc #(
  parameter int DW    = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DW-1:0]    rdata,
  input  logic [DW-1:0]    expect_w,
  output logic [CNT_W-1:0] cnt
);
  localparam int PW = $clog2(DW + 1);
  localparam int SW = (CNT_W > PW) ? CNT_W + 1 : PW + 1;
  localparam logic [SW-1:0] MAXV = SW'({CNT_W{1'b1}});

  function automatic logic [PW-1:0] popc(input logic [DW-1:0] v);
    logic [PW-1:0] s;
    s = '0;
    for (int i = 0; i < DW; i++) s = s + PW'(v[i]);
    return s;
  endfunction

  logic [SW-1:0] sum;
  assign sum = SW'(cnt) + SW'(popc(rdata ^ expect_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (en)   cnt <= (sum > MAXV) ? MAXV[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/dram_margin_seq.sv
module dram_margin_seq
  import dram_margin_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 8,
  parameter int COL_W   = 6,
  parameter int DW      = 16,
  parameter int DLY_W   = 4,
  parameter int CNT_W   = 8,
  parameter int NOM_DLY = 6,
  parameter int N_LINES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              test_mode,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [ROW_W-1:0]  cfg_row,
  input  logic [ROW_W-1:0]  cfg_alt_row,
  input  logic [COL_W-1:0]  cfg_col,
  input  logic [1:0]        cfg_pattern,
  input  logic [DLY_W-1:0]  cfg_delay,
  output logic              busy,
  output logic              done,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DW-1:0]     wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DW-1:0]     rd_data,
  output logic [CNT_W-1:0]  err_fast,
  output logic [CNT_W-1:0]  err_ref
);
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam logic [DLY_W-1:0] NOM  = DLY_W'(NOM_DLY);
  localparam logic [DLY_W-1:0] ONE  = DLY_W'(1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LINES - 1);

  seq_state_e state_q, ret_q, nxt, nxt_ret, tgt;
  logic [IDX_W-1:0]  idx_q, nxt_idx;
  logic              mode_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q, alt_q;
  logic [COL_W-1:0]  col_q;
  logic [1:0]        pat_q;
  logic [DLY_W-1:0]  dly_q, gap, tmr_val;
  logic              tmr_load, tmr_zero, accept, xfer;
  logic [DW-1:0]     pat_word;

  assign accept = (state_q == S_IDLE) && start;
  assign xfer   = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ret_q   <= S_IDLE;
      idx_q   <= '0;
      mode_q  <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      alt_q   <= '0;
      col_q   <= '0;
      pat_q   <= '0;
      dly_q   <= ONE;
    end else begin
      state_q <= nxt;
      ret_q   <= nxt_ret;
      idx_q   <= nxt_idx;
      if (accept) begin
        mode_q <= test_mode;
        bank_q <= cfg_bank;
        row_q  <= cfg_row;
        alt_q  <= cfg_alt_row;
        col_q  <= cfg_col;
        pat_q  <= cfg_pattern;
        dly_q  <= (cfg_delay == '0) ? ONE : cfg_delay;
      end
    end
  end

  // Next-state: each state names a target and the spacing to it;
  // spacings above one cycle pass through the shared wait state.
  always_comb begin
    tgt     = state_q;
    gap     = ONE;
    nxt_idx = idx_q;
    case (state_q)
      S_IDLE:   if (start) tgt = S_P_ACT;
      S_WAIT:   tgt = tmr_zero ? ret_q : S_WAIT;
      S_P_ACT:  begin tgt = S_P_WR; gap = NOM; end
      S_P_WR: begin
        if (idx_q == LAST) begin
          tgt = S_P_PRE; gap = NOM; nxt_idx = '0;
        end else begin
          nxt_idx = idx_q + IDX_W'(1);
        end
      end
      S_P_PRE:  begin tgt = mode_q ? S_C_ACTO : S_A_ACT; gap = NOM; end
      S_A_ACT:  begin tgt = S_A_RD; gap = dly_q; end
      S_A_RD:   tgt = S_A_RW;
      S_A_RW:   if (xfer) begin tgt = S_A_RD2; gap = NOM; end
      S_A_RD2:  tgt = S_A_RW2;
      S_A_RW2:  if (xfer) tgt = S_F_PRE;
      S_C_ACTO: begin tgt = S_C_PRE; gap = NOM; end
      S_C_PRE:  begin tgt = S_C_ACT; gap = dly_q; end
      S_C_ACT:  begin tgt = S_C_RD; gap = NOM; end
      S_C_RD:   tgt = S_C_RW;
      S_C_RW: begin
        if (xfer) begin
          if (idx_q == LAST) begin
            tgt = S_C_PRE2; gap = NOM; nxt_idx = '0;
          end else begin
            tgt = S_C_RD; nxt_idx = idx_q + IDX_W'(1);
          end
        end
      end
      S_C_PRE2: begin tgt = S_C_ACT2; gap = NOM; end
      S_C_ACT2: begin tgt = S_C_RD2; gap = NOM; end
      S_C_RD2:  tgt = S_C_RW2;
      S_C_RW2: begin
        if (xfer) begin
          if (idx_q == LAST) begin
            tgt = S_F_PRE; nxt_idx = '0;
          end else begin
            tgt = S_C_RD2; nxt_idx = idx_q + IDX_W'(1);
          end
        end
      end
      S_F_PRE:  begin tgt = S_DONE; gap = NOM; end
      S_DONE:   tgt = S_IDLE;
      default:  tgt = S_IDLE;
    endcase

    nxt      = tgt;
    nxt_ret  = ret_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (gap > ONE) begin
      nxt      = S_WAIT;
      nxt_ret  = tgt;
      tmr_load = 1'b1;
      tmr_val  = gap - DLY_W'(2);
    end
  end

  dmt_gap_timer #(.W(DLY_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .val   (tmr_val),
    .zero  (tmr_zero)
  );

  // Command outputs
  always_comb begin
    case (state_q)
      S_P_ACT, S_A_ACT, S_C_ACTO, S_C_ACT, S_C_ACT2: cmd = CMD_ACT;
      S_P_WR:                                        cmd = CMD_WR;
      S_A_RD, S_A_RD2, S_C_RD, S_C_RD2:              cmd = CMD_RD;
      S_P_PRE, S_C_PRE, S_C_PRE2, S_F_PRE:           cmd = CMD_PRE;
      default:                                       cmd = CMD_NOP;
    endcase
  end

  assign cmd_bank = bank_q;
  assign cmd_row  = (state_q == S_C_ACTO) ? alt_q : row_q;
  assign cmd_col  = col_q + COL_W'(idx_q);
  assign rd_ready = (state_q == S_A_RW) || (state_q == S_A_RW2) ||
                    (state_q == S_C_RW) || (state_q == S_C_RW2);
  assign busy     = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done     = (state_q == S_DONE);

  dmt_pattern #(.DW(DW)) u_pat (
    .sel     (pat_q),
    .odd_col (cmd_col[0]),
    .word    (pat_word)
  );
  assign wr_data = pat_word;

  // Two error lanes: 0 = reduced-timing reads, 1 = full-timing reads
  logic [1:0]       lane_en;
  logic [CNT_W-1:0] lane_cnt [2];
  assign lane_en[0] = xfer && ((state_q == S_A_RW)  || (state_q == S_C_RW));
  assign lane_en[1] = xfer && ((state_q == S_A_RW2) || (state_q == S_C_RW2));

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dmt_err_acc #(.DW(DW), .CNT_W(CNT_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .en       (lane_en[g]),
      .rdata    (rd_data),
      .expect_w (pat_word),
      .cnt      (lane_cnt[g])
    );
  end

  assign err_fast = lane_cnt[0];
  assign err_ref  = lane_cnt[1];

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(bank_q) && $stable(row_q) && $stable(dly_q)));

  // R10
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> cmd == CMD_NOP);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid) |=> rd_ready);
endmodule

// File: tb/tb_dram_margin_seq.sv
module tb_dram_margin_seq;
  localparam int NOM   = 6;
  localparam int NL    = 4;
  localparam int CW    = 6;
  localparam int SLOW  = 4;
  localparam int WCOL  = 10;
  localparam int MAXC  = 63;
  localparam logic [15:0] FA = 16'h0C00;
  localparam logic [15:0] FP = 16'h0090;

  logic clk = 0, rst_n = 0, start = 0, test_mode = 0;
  logic [1:0] cfg_bank = 0, cfg_pattern = 0;
  logic [7:0] cfg_row = 0, cfg_alt_row = 0;
  logic [5:0] cfg_col = 0;
  logic [3:0] cfg_delay = 0;
  logic busy, done, rd_ready;
  logic [2:0] cmd;
  logic [1:0] cmd_bank;
  logic [7:0] cmd_row;
  logic [5:0] cmd_col;
  logic [15:0] wr_data, rd_data;
  logic rd_valid;
  logic [5:0] err_fast, err_ref;

  dram_margin_seq #(.CNT_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_mode(test_mode),
    .cfg_bank(cfg_bank), .cfg_row(cfg_row), .cfg_alt_row(cfg_alt_row),
    .cfg_col(cfg_col), .cfg_pattern(cfg_pattern), .cfg_delay(cfg_delay),
    .busy(busy), .done(done), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .err_fast(err_fast), .err_ref(err_ref));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat_word(input int p, input int col);
    case (p)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h5555;
      default: return (col % 2) ? 16'hAAAA : 16'h5555;
    endcase
  endfunction

  function automatic int stuck(input int p, input int col);
    logic [15:0] w;
    w = pat_word(p, col);
    return (col == WCOL && w[5]) ? 1 : 0;
  endfunction

  // memory model state
  logic [15:0] mem [int];
  int act_cyc [4], pre_cyc [4], open_row [4];
  bit first_rd [4], pre_hit [4];
  int q_time [$];
  logic [15:0] q_data [$];
  bit took = 0, inv_mode = 0;
  int cur_bank = 0, cur_pat = 0;
  int n_wr, n_rd, bank_bad, wr_bad, min_ar, min_pa;

  initial begin
    for (int i = 0; i < 4; i++) begin
      act_cyc[i] = -1000; pre_cyc[i] = -1000; open_row[i] = 0;
      first_rd[i] = 0; pre_hit[i] = 0;
    end
    rd_valid = 0; rd_data = 0;
  end

  always @(negedge clk) begin
    int bk, g, k;
    logic [15:0] d;
    cyc++;
    if (rst_n) begin
      bk = int'(cmd_bank);
      if (cmd != 3'd0 && bk != cur_bank) bank_bad++;
      case (cmd)
        3'd1: begin
          g = cyc - pre_cyc[bk];
          if (g < min_pa) min_pa = g;
          act_cyc[bk] = cyc; first_rd[bk] = 1;
          pre_hit[bk] = (g < SLOW); open_row[bk] = int'(cmd_row);
        end
        3'd3: begin
          k = (bk << 14) | (open_row[bk] << 6) | int'(cmd_col);
          mem[k] = wr_data; n_wr++;
          if (wr_data != pat_word(cur_pat, int'(cmd_col))) wr_bad++;
        end
        3'd2: begin
          k = (bk << 14) | (open_row[bk] << 6) | int'(cmd_col);
          d = mem.exists(k) ? mem[k] : 16'h0;
          if (int'(cmd_col) == WCOL) d[5] = 1'b0;
          if (first_rd[bk]) begin
            g = cyc - act_cyc[bk];
            if (g < min_ar) min_ar = g;
            if (g < SLOW) d = d ^ (inv_mode ? 16'hFFFF : FA);
          end
          if (pre_hit[bk]) d = d ^ (inv_mode ? 16'hFFFF : FP);
          first_rd[bk] = 0; n_rd++;
          q_time.push_back(cyc + 2 + int'($urandom % 3));
          q_data.push_back(d);
        end
        3'd4: pre_cyc[bk] = cyc;
        default: ;
      endcase
      // read return stream
      if (took) begin
        void'(q_time.pop_front()); void'(q_data.pop_front());
        rd_valid = 0;
      end
      if (!rd_valid && q_time.size() > 0 && q_time[0] <= cyc) begin
        rd_valid = 1; rd_data = q_data[0];
      end
      took = rd_valid && rd_ready;
    end
  end

  task automatic run_test(input int mode, input int pat, input int dly, input int bank,
                          input int row, input int alt, input int col,
                          input bit inv, input bit poke_start);
    int eff, s, ef, er, hf, hr;
    bit seen;
    inv_mode = inv; cur_bank = bank; cur_pat = pat;
    n_wr = 0; n_rd = 0; bank_bad = 0; wr_bad = 0; min_ar = 1000; min_pa = 1000;
    @(negedge clk);
    test_mode = mode[0]; cfg_pattern = pat[1:0]; cfg_delay = dly[3:0];
    cfg_bank = bank[1:0]; cfg_row = row[7:0]; cfg_alt_row = alt[7:0]; cfg_col = col[5:0];
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R2 busy after start", int'(busy), 1);
    chk(err_fast == 0 && err_ref == 0, "R11 cleared at start", int'(err_fast) + int'(err_ref), 0);
    if (poke_start) begin
      repeat (3) @(negedge clk);
      cfg_bank = cfg_bank + 2'd1; cfg_delay = 4'd9; start = 1;
      @(negedge clk);
      start = 0;
    end
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R2 done pulse seen", int'(seen), 1);
    chk(busy == 0, "R2 busy low with done", int'(busy), 0);
    eff = (dly == 0) ? 1 : dly;
    s = 0;
    if (mode == 0) s = stuck(pat, col);
    else for (int i = 0; i < NL; i++) s += stuck(pat, (col + i) % 64);
    ef = s + ((eff < SLOW) ? (mode == 0 ? 1 : NL) * (inv ? 16 : 2) : 0);
    er = s;
    if (ef > MAXC) ef = MAXC;
    chk(int'(err_fast) == ef, (ef == MAXC) ? "R9 saturated fast count" : "R8 fast count",
        int'(err_fast), ef);
    chk(int'(err_ref) == er, "R8 reference count", int'(err_ref), er);
    chk(n_wr == NL, "R4 preparation writes", n_wr, NL);
    chk(wr_bad == 0, "R7 write pattern", wr_bad, 0);
    chk(bank_bad == 0, poke_start ? "R3 R13 bank kept" : "R13 bank on commands", bank_bad, 0);
    if (mode == 0) begin
      chk(n_rd == 2, "R5 R10 read count", n_rd, 2);
      chk(min_ar == eff, "R5 R12 act-to-read gap", min_ar, eff);
    end else begin
      chk(n_rd == 2 * NL, "R6 R10 read count", n_rd, 2 * NL);
      chk(min_pa == ((eff < NOM) ? eff : NOM), "R6 R12 pre-to-act gap", min_pa,
          (eff < NOM) ? eff : NOM);
      chk(min_ar == NOM, "R6 act-to-read full gap", min_ar, NOM);
    end
    hf = int'(err_fast); hr = int'(err_ref);
    @(negedge clk);
    chk(done == 0, "R2 done one cycle", int'(done), 0);
    chk(int'(err_fast) == hf && int'(err_ref) == hr, "R11 counts hold", int'(err_fast), hf);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(done == 0, "R1 done", int'(done), 0);
    chk(cmd == 3'd0, "R1 cmd NOP", int'(cmd), 0);
    chk(rd_ready == 0, "R1 rd_ready", int'(rd_ready), 0);
    chk(err_fast == 0 && err_ref == 0, "R1 counts", int'(err_fast) + int'(err_ref), 0);
    // directed corners
    run_test(0, 1, 0, 1, 17, 40, 10, 0, 0);   // R12 delay 0 clamps, stuck bit hit
    run_test(1, 3, 1, 2, 5, 6, 9, 0, 0);      // R6 shortest precharge spacing
    run_test(0, 2, 6, 0, 99, 1, 10, 0, 0);    // R12 nominal value
    run_test(1, 1, 15, 3, 200, 7, 8, 0, 0);   // R12 above nominal
    run_test(1, 0, 1, 1, 30, 31, 20, 1, 0);   // R9 saturation
    run_test(1, 3, 2, 0, 12, 13, 62, 0, 0);   // R4 column wrap
    run_test(0, 1, 2, 2, 44, 45, 11, 0, 1);   // R3 start while busy
    for (int t = 0; t < 24; t++) begin
      int r, c;
      r = int'($urandom % 256);
      c = ($urandom % 2) ? 8 + int'($urandom % 4) : int'($urandom % 64);
      run_test(int'($urandom % 2), int'($urandom % 4), int'($urandom % 10),
               int'($urandom % 4), r, r ^ (1 + int'($urandom % 255)), c, 0, 0);
    end
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule